// File: doc/BRIEF.md
# Block Transfer Address Generator

This block turns one multi-register memory transfer request into a stream of single-word beats. A request carries a 32-bit base address, a 16-bit bitmap of the registers to move, one of four addressing modes, a load/store direction flag and a writeback enable. The block walks the bitmap from the lowest set bit to the highest. Each beat carries one register index, the word address for it and the direction. Beats go out one per cycle under a valid/ready handshake.

The four modes choose whether the base is stepped up or down, and whether the step comes before or after each access. The transfer always occupies a contiguous window of words, and the lowest-numbered register always lands at the lowest address of that window. In the down modes the block therefore computes the bottom of the window first, as the base minus four bytes per listed register. When the last beat has been accepted, the block pulses a completion flag for one cycle. With writeback enabled it also presents the updated base for the register file to store. The memory and the register file are outside the block.

Top module: `blk_xfer_agen`

## Requirements
- R1: After synchronous reset, `busy_o`, `beat_valid_o`, `done_o` and `wb_valid_o` are all low.
- R2: The up modes are encoded as `mode_i` = 0 (access, then step) and 1 (step, then access). The first beat's address is the base for code 0 and the base plus 4 for code 1.
- R3: The down modes are encoded as `mode_i` = 2 (access, then step) and 3 (step, then access). With n set bits in the list, the first beat's address is base − 4n + 4 for code 2 and base − 4n for code 3.
- R4: Each accepted beat that is not the last is followed by a beat whose address is exactly 4 higher. Addresses wrap modulo 2^32.
- R5: Beats carry exactly the register indices that are set in the list, each once, in ascending order. The number of beats equals the population count of the list.
- R6: While `beat_valid_o` is high and `beat_ready_i` is low, the beat holds with register index and address unchanged. With ready high, one beat is consumed on every cycle.
- R7: `wb_valid_o` is high in the completion cycle exactly when writeback was requested. `wb_base_o` then equals base + 4n for codes 0 and 1, and base − 4n for codes 2 and 3.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last beat is accepted. `busy_o` is low in that same cycle.
- R9: An empty list produces no beat. `done_o` is then high in the cycle after the start, and `wb_base_o` equals the unchanged base.
- R10: A start strobe that arrives while `busy_o` is high is ignored, and the running transfer continues unaltered.
- R11: Every beat's `beat_load_o` equals the `is_load_i` value captured with the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| base_i | input | 32 | Base byte address |
| list_i | input | 16 | Register bitmap, bit k selects register k |
| mode_i | input | 2 | Addressing mode code (0..3) |
| is_load_i | input | 1 | 1 = load, 0 = store |
| wb_en_i | input | 1 | Request base writeback |
| busy_o | output | 1 | Transfer in progress |
| beat_valid_o | output | 1 | Beat available |
| beat_ready_i | input | 1 | Consumer accepts the beat |
| beat_reg_o | output | 4 | Register index of the beat |
| beat_addr_o | output | 32 | Word address of the beat |
| beat_load_o | output | 1 | Direction of the beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback base is valid |
| wb_base_o | output | 32 | Updated base value |

## Verification
The first beat is due in the cycle right after the start edge, because the request registers are its only stage. Each further beat follows one cycle after an accepted one, and the completion pulse, together with the writeback value, comes one cycle after the final acceptance, or one cycle after the start for an empty list. The bench drives inputs on falling edges and samples at the next falling edge. It walks the handshake cycle by cycle, so each beat is compared in the cycle it is presented, and a stalled beat is compared again against its earlier copy. The completion pulse is checked in its own cycle and then checked low in the cycle that follows.

// File: rtl/bxag_pkg.sv
package bxag_pkg;

    localparam int AW         = 32;
    localparam int NREGS      = 16;
    localparam int IDX_W      = $clog2(NREGS);
    localparam int CNT_W      = $clog2(NREGS + 1);
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        AM_UP_POST = 2'd0,
        AM_UP_PRE  = 2'd1,
        AM_DN_POST = 2'd2,
        AM_DN_PRE  = 2'd3
    } addr_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    addr;
        logic             load;
    } beat_t;

    typedef struct packed {
        logic [AW-1:0] first;
        logic [AW-1:0] final_base;
    } plan_t;

    function automatic logic [CNT_W-1:0] bits_set(input logic [NREGS-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < NREGS; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/bxag_plan.sv
module bxag_plan
    import bxag_pkg::*;
#(
    parameter int P_AW    = AW,
    parameter int P_NREGS = NREGS,
    parameter int P_STEP  = WORD_BYTES
) (
    input  logic [P_AW-1:0]    base_i,
    input  logic [P_NREGS-1:0] list_i,
    input  addr_mode_e         mode_i,
    output plan_t              plan_o
);
    localparam int SH = $clog2(P_STEP);

    logic [P_AW-1:0] span;
    logic [P_AW-1:0] bottom;
    logic            down;
    logic            pre;

    always_comb begin
        span   = P_AW'(bits_set(list_i)) << SH;
        down   = mode_i[1];
        pre    = mode_i[0];
        bottom = down ? (base_i - span) : base_i;
        plan_o.first      = (pre ^ down) ? (bottom + P_AW'(P_STEP)) : bottom;
        plan_o.final_base = down ? (base_i - span) : (base_i + span);
    end

endmodule

// File: rtl/bxag_pick.sv
module bxag_pick #(
    parameter int N   = 16,
    parameter int IW  = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [N-1:0]  onehot_o,
    output logic [IW-1:0] idx_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign onehot_o[g] = vec_i[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | vec_i[g];
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_o[i]) idx_o = idx_o | IW'(i);
        end
    end

endmodule

// File: rtl/blk_xfer_agen.sv
module blk_xfer_agen
    import bxag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [AW-1:0]    base_i,
    input  logic [NREGS-1:0] list_i,
    input  logic [1:0]       mode_i,
    input  logic             is_load_i,
    input  logic             wb_en_i,
    output logic             busy_o,
    output logic             beat_valid_o,
    input  logic             beat_ready_i,
    output logic [IDX_W-1:0] beat_reg_o,
    output logic [AW-1:0]    beat_addr_o,
    output logic             beat_load_o,
    output logic             done_o,
    output logic             wb_valid_o,
    output logic [AW-1:0]    wb_base_o
);
    plan_t            plan;
    logic             busy_q;
    logic             done_q;
    logic             wb_q;
    logic             load_q;
    logic [NREGS-1:0] left_q;
    logic [AW-1:0]    addr_q;
    logic [AW-1:0]    final_q;
    logic [NREGS-1:0] pick_oh;
    logic [IDX_W-1:0] pick_idx;
    logic             take;
    logic             fire;
    logic             last;
    beat_t            beat;

    bxag_plan #(.P_AW(AW), .P_NREGS(NREGS), .P_STEP(WORD_BYTES)) u_plan (
        .base_i (base_i),
        .list_i (list_i),
        .mode_i (addr_mode_e'(mode_i)),
        .plan_o (plan)
    );

    bxag_pick #(.N(NREGS), .IW(IDX_W)) u_pick (
        .vec_i    (left_q),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx)
    );

    assign take = start_i & ~busy_q;
    assign fire = busy_q & beat_ready_i;
    assign last = ~|(left_q & ~pick_oh);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            wb_q    <= 1'b0;
            load_q  <= 1'b0;
            left_q  <= '0;
            addr_q  <= '0;
            final_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                left_q  <= list_i;
                addr_q  <= plan.first;
                final_q <= plan.final_base;
                load_q  <= is_load_i;
                wb_q    <= wb_en_i;
                busy_q  <= |list_i;
                done_q  <= ~|list_i;
            end else if (fire) begin
                left_q <= left_q & ~pick_oh;
                addr_q <= addr_q + AW'(WORD_BYTES);
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        beat.idx  = pick_idx;
        beat.addr = addr_q;
        beat.load = load_q;
    end

    assign busy_o       = busy_q;
    assign beat_valid_o = busy_q;
    assign beat_reg_o   = beat.idx;
    assign beat_addr_o  = beat.addr;
    assign beat_load_o  = beat.load;
    assign done_o       = done_q;
    assign wb_valid_o   = done_q & wb_q;
    assign wb_base_o    = final_q;

    // R4: address rises by one word between consecutive beats
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && !last) |=> (beat_addr_o == $past(beat_addr_o) + AW'(WORD_BYTES)));

    // R5: register indices strictly ascend
    a_r5_reg_ascend: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && !last) |=> (beat_valid_o && beat_reg_o > $past(beat_reg_o)));

    // R6: stalled beat holds
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_addr_o) && $stable(beat_reg_o)));

    // R8: completion follows last acceptance and lasts one cycle
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && beat_ready_i && last) |=> (done_o && !busy_o));
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: empty request completes at once with the base untouched
    a_r9_empty_list: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && list_i == '0) |=> (done_o && !beat_valid_o && wb_base_o == $past(base_i)));

    // R10: start while busy leaves the transfer alone
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(wb_base_o) && $stable(beat_load_o)));

endmodule

// File: tb/blk_xfer_agen_tb.sv
module blk_xfer_agen_tb;
    import bxag_pkg::*;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] base;
        logic [15:0] list;
        logic        load;
        logic        wb;
        logic        stall;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_1000, 16'h002A, 1'b0, 1'b1, 1'b0},
        '{2'd1, 32'h0000_1000, 16'h002A, 1'b1, 1'b1, 1'b0},
        '{2'd2, 32'h0000_1000, 16'h002A, 1'b0, 1'b1, 1'b1},
        '{2'd3, 32'h0000_1000, 16'h002A, 1'b1, 1'b0, 1'b0},
        '{2'd3, 32'h0000_2000, 16'hFFFF, 1'b0, 1'b1, 1'b1},
        '{2'd0, 32'h0000_0010, 16'h8001, 1'b1, 1'b1, 1'b1},
        '{2'd2, 32'h0000_0100, 16'h0001, 1'b0, 1'b1, 1'b0},
        '{2'd1, 32'hFFFF_FFF8, 16'h0003, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] list_i = '0;
    logic [1:0]  mode_i = '0;
    logic        is_load_i = 1'b0;
    logic        wb_en_i = 1'b0;
    logic        beat_ready_i = 1'b0;
    logic        busy_o, beat_valid_o, beat_load_o, done_o, wb_valid_o;
    logic [3:0]  beat_reg_o;
    logic [31:0] beat_addr_o, wb_base_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    blk_xfer_agen u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .list_i(list_i),
        .mode_i(mode_i), .is_load_i(is_load_i), .wb_en_i(wb_en_i), .busy_o(busy_o),
        .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i), .beat_reg_o(beat_reg_o),
        .beat_addr_o(beat_addr_o), .beat_load_o(beat_load_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int nset(input logic [15:0] l);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(l[i]);
        return n;
    endfunction

    function automatic logic [31:0] exp_first(input logic [1:0] m, input logic [31:0] b, input logic [15:0] l);
        logic [31:0] sp = 32'(4 * nset(l));
        case (m)
            2'd0:    return b;
            2'd1:    return b + 32'd4;
            2'd2:    return b - sp + 32'd4;
            default: return b - sp;
        endcase
    endfunction

    function automatic logic [31:0] exp_final(input logic [1:0] m, input logic [31:0] b, input logic [15:0] l);
        logic [31:0] sp = 32'(4 * nset(l));
        return m[1] ? b - sp : b + sp;
    endfunction

    // Runs one request; junk=1 keeps a bogus start strobe raised while busy (R10)
    task automatic run_vec(input vec_t v, input bit junk);
        logic [31:0] a;
        int          k;
        int          nb;
        bit          held;
        logic [3:0]  hreg;
        logic [31:0] haddr;
        a    = exp_first(v.mode, v.base, v.list);
        k    = 0;
        nb   = 0;
        held = 1'b0;
        hreg = '0;
        haddr = '0;
        @(negedge clk);
        start_i = 1'b1; base_i = v.base; list_i = v.list; mode_i = v.mode;
        is_load_i = v.load; wb_en_i = v.wb; beat_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            if (done_o) begin
                start_i = 1'b0;
                chk(nb == nset(v.list), "R5 beat count", 32'(nb), 32'(nset(v.list)));
                chk(!busy_o, "R8 busy low at done", 32'(busy_o), 32'd0);
                chk(wb_valid_o == v.wb, "R7 wb_valid", 32'(wb_valid_o), 32'(v.wb));
                if (v.wb) chk(wb_base_o == exp_final(v.mode, v.base, v.list), "R7 wb_base",
                              wb_base_o, exp_final(v.mode, v.base, v.list));
                @(negedge clk);
                chk(!done_o, "R8 done single cycle", 32'(done_o), 32'd0);
                return;
            end
            if (junk) begin
                start_i = 1'b1; base_i = 32'hDEAD_0000; list_i = 16'h0F0F;
                mode_i = 2'd3; is_load_i = ~v.load; wb_en_i = ~v.wb;
            end
            if (held) begin
                chk(beat_reg_o == hreg, "R6 stall reg hold", 32'(beat_reg_o), 32'(hreg));
                chk(beat_addr_o == haddr, "R6 stall addr hold", beat_addr_o, haddr);
            end
            beat_ready_i = !(v.stall && (cyc % 3 == 1));
            if (beat_valid_o) begin
                while (k < 16 && !v.list[k]) k++;
                chk(beat_reg_o == 4'(k), "R5 register order", 32'(beat_reg_o), 32'(k));
                if (nb == 0) chk(beat_addr_o == a, v.mode[1] ? "R3 first address" : "R2 first address",
                                 beat_addr_o, a);
                else chk(beat_addr_o == a, "R4 address step", beat_addr_o, a);
                chk(beat_load_o == v.load, "R11 load flag", 32'(beat_load_o), 32'(v.load));
                held  = !beat_ready_i;
                hreg  = beat_reg_o;
                haddr = beat_addr_o;
                if (beat_ready_i) begin
                    nb++;
                    k++;
                    a = a + 32'd4;
                end
            end else begin
                held = 1'b0;
            end
            @(negedge clk);
        end
        chk(1'b0, "R8 done never seen", 32'(nb), 32'(nset(v.list)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o, "R1 busy", 32'(busy_o), 32'd0);
        chk(!beat_valid_o, "R1 valid", 32'(beat_valid_o), 32'd0);
        chk(!done_o, "R1 done", 32'(done_o), 32'd0);
        chk(!wb_valid_o, "R1 wb_valid", 32'(wb_valid_o), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R9 empty list: done in the cycle after start, base unchanged
        @(negedge clk);
        start_i = 1'b1; base_i = 32'h0000_4440; list_i = 16'h0000; mode_i = 2'd3;
        wb_en_i = 1'b1; beat_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o, "R9 empty done", 32'(done_o), 32'd1);
        chk(!beat_valid_o, "R9 empty no beat", 32'(beat_valid_o), 32'd0);
        chk(wb_base_o == 32'h0000_4440, "R9 empty base kept", wb_base_o, 32'h0000_4440);
        @(negedge clk);
        chk(!done_o && !beat_valid_o, "R9 no later beat", 32'({done_o, beat_valid_o}), 32'd0);

        // R10 start strobes while busy are ignored
        run_vec('{2'd0, 32'h0000_0800, 16'h1234, 1'b1, 1'b1, 1'b1}, 1'b1);
        @(negedge clk);
        chk(!busy_o && !beat_valid_o, "R10 no extra transfer", 32'({busy_o, beat_valid_o}), 32'd0);

        // R1 reset in mid-transfer clears outputs
        @(negedge clk);
        start_i = 1'b1; base_i = 32'h100; list_i = 16'h00FF; mode_i = 2'd0; beat_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && !beat_valid_o && !done_o, "R1 mid-run reset",
            32'({busy_o, beat_valid_o, done_o}), 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule